// File: doc/BRIEF.md
# Neighbour Mailbox Register File

This block is a ring of small register banks, one per core, that lets cores hand data to each other without going through a central shared memory. Each core owns a bank of 32-bit words. Only that core's write port can change its bank. Any core can read any word of any bank through its own read port, and all read ports work in the same cycle.

Two words of every bank act as mailboxes toward the ring neighbours. A core's left and right mailbox views are kept in registers beside the core, so polling them costs no read port. Each view has a flag that is high while its word is zero, which lets a waiting core poll for "message present" in one cycle. The cores form a ring: the first core and the last core are neighbours.

A sender writes a word in one clock. The receiving core's mailbox view shows that word after the next clock edge, so a poll loop picks it up with a fixed and known latency.

Top module: `nbr_mailbox_bank`

## Requirements
- R1: A synchronous active-high reset clears every stored word to zero. After reset, every `rd_valid` bit is 0, all read data and mailbox views are 0, and every zero flag is 1.
- R2: When `own_we[i]` is high at a clock edge, the word at index `own_idx` of bank i takes the value `own_wdata`. Only write port i changes bank i. When `own_we[i]` is low, bank i keeps its contents whatever its index and data inputs carry.
- R3: When `rd_en[j]` is high at an edge, then after that edge `rd_data[j]` holds word `rd_idx[j]` of bank `rd_core[j]` and `rd_valid[j]` is 1. In a cycle without `rd_en[j]`, `rd_valid[j]` is 0 and `rd_data[j]` keeps its previous value. The core number is plain binary.
- R4: Any number of read ports may read the same word in the same cycle, and all of them return the same value.
- R5: A read and a write of the same word at the same edge return the old value. A read at a later edge returns the new value.
- R6: The left mailbox view of core i (`lt_data`) shows word 0 of bank i-1. The right mailbox view (`rt_data`) shows word 1 of bank i+1. A word written at edge t appears in these views after edge t+1 and never earlier.
- R7: The ring wraps around. The left neighbour of core 0 is core N-1, and the right neighbour of core N-1 is core 0.
- R8: `lt_zero[i]` is 1 exactly when `lt_data[i]` is zero, and `rt_zero[i]` is 1 exactly when `rt_data[i]` is zero.
- R9: All write ports may write in the same cycle, and every one of those writes takes effect in its own bank.

## Ports
Per-core fields are packed so that core i occupies bits `[i*W +: W]`, where W is the field width.

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| own_we | input | N_CORES | Write enable of each core's owner port |
| own_idx | input | N_CORES*IW | Word index of each owner write |
| own_wdata | input | N_CORES*DATA_W | Data of each owner write |
| rd_en | input | N_CORES | Read request of each core's read port |
| rd_core | input | N_CORES*CW | Bank (core number) each read port selects |
| rd_idx | input | N_CORES*IW | Word index each read port selects |
| rd_data | output | N_CORES*DATA_W | Registered read result per port |
| rd_valid | output | N_CORES | High for the cycle after a read request |
| lt_data | output | N_CORES*DATA_W | Left mailbox view per core |
| rt_data | output | N_CORES*DATA_W | Right mailbox view per core |
| lt_zero | output | N_CORES | Left mailbox view is zero |
| rt_zero | output | N_CORES | Right mailbox view is zero |

## Verification
The hardest case to reach from the ports is a word that is written and read at the same edge while other ports write to the neighbouring mailbox words. In that case the old and new values have to be told apart, and the two-edge mailbox latency has to be confirmed at the same time.

Random stimulus pushes half of the write indices onto the two mailbox words and makes a fifth of the write data zero. This produces frequent same-word collisions and frequent zero-flag transitions. Directed steps then force the following cases:
- a read-during-write on one word;
- all ports reading one word together;
- all ports writing together;
- writes with the enable low;
- traffic across the wrap point between the last core and core 0.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  // Word of a bank read by the right-hand neighbour as its left mailbox.
  localparam int SLOT_EAST = 0;
  // Word of a bank read by the left-hand neighbour as its right mailbox.
  localparam int SLOT_WEST = 1;

  function automatic int ring_prev(input int i, input int n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  function automatic int ring_next(input int i, input int n);
    return (i == n - 1) ? 0 : i + 1;
  endfunction
endpackage

// File: rtl/mbx_owner_bank.sv
`timescale 1ns/1ps
module mbx_owner_bank #(
  parameter int REGS   = 16,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(REGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IW-1:0]          widx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [REGS*DATA_W-1:0] q_flat
);
  logic [DATA_W-1:0] mem [REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < REGS; k++) mem[k] <= '0;
    end else if (we && (int'(widx) < REGS)) begin
      mem[widx] <= wdata;
    end
  end

  for (genvar k = 0; k < REGS; k++) begin : g_out
    assign q_flat[k*DATA_W +: DATA_W] = mem[k];
  end
endmodule

// File: rtl/mbx_read_port.sv
`timescale 1ns/1ps
module mbx_read_port #(
  parameter int N_CORES = 16,
  parameter int REGS    = 16,
  parameter int DATA_W  = 32,
  localparam int CW     = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int IW     = $clog2(REGS),
  localparam int TOT    = N_CORES * REGS,
  localparam int SW     = $clog2(TOT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [CW-1:0]         core_sel,
  input  logic [IW-1:0]         idx_sel,
  input  logic [TOT*DATA_W-1:0] bank_flat,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rvalid
);
  logic [DATA_W-1:0] words [TOT];
  logic [SW-1:0]     sel;
  logic [DATA_W-1:0] pick;

  for (genvar k = 0; k < TOT; k++) begin : g_view
    assign words[k] = bank_flat[k*DATA_W +: DATA_W];
  end

  always_comb begin
    sel  = SW'(core_sel) * SW'(REGS) + SW'(idx_sel);
    pick = '0;
    if ((int'(core_sel) < N_CORES) && (int'(idx_sel) < REGS)) pick = words[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= en;
      if (en) rdata <= pick;
    end
  end
endmodule

// File: rtl/mbx_ring_tap.sv
`timescale 1ns/1ps
module mbx_ring_tap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] from_left,
  input  logic [DATA_W-1:0] from_right,
  output logic [DATA_W-1:0] lt_q,
  output logic [DATA_W-1:0] rt_q,
  output logic              lt_z,
  output logic              rt_z
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lt_q <= '0;
      rt_q <= '0;
    end else begin
      lt_q <= from_left;
      rt_q <= from_right;
    end
  end

  assign lt_z = (lt_q == '0);
  assign rt_z = (rt_q == '0);
endmodule

// File: rtl/nbr_mailbox_bank.sv
`timescale 1ns/1ps
module nbr_mailbox_bank #(
  parameter int N_CORES       = 16,
  parameter int REGS_PER_CORE = 16,
  parameter int DATA_W        = 32,
  localparam int CW           = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int IW           = $clog2(REGS_PER_CORE)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES-1:0]        own_we,
  input  logic [N_CORES*IW-1:0]     own_idx,
  input  logic [N_CORES*DATA_W-1:0] own_wdata,
  input  logic [N_CORES-1:0]        rd_en,
  input  logic [N_CORES*CW-1:0]     rd_core,
  input  logic [N_CORES*IW-1:0]     rd_idx,
  output logic [N_CORES*DATA_W-1:0] rd_data,
  output logic [N_CORES-1:0]        rd_valid,
  output logic [N_CORES*DATA_W-1:0] lt_data,
  output logic [N_CORES*DATA_W-1:0] rt_data,
  output logic [N_CORES-1:0]        lt_zero,
  output logic [N_CORES-1:0]        rt_zero
);
  localparam int BANK_BITS = REGS_PER_CORE * DATA_W;

  logic [N_CORES*BANK_BITS-1:0] all_banks;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    localparam int PV = mbx_pkg::ring_prev(i, N_CORES);
    localparam int NX = mbx_pkg::ring_next(i, N_CORES);

    mbx_owner_bank #(.REGS(REGS_PER_CORE), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (own_we[i]),
      .widx  (own_idx[i*IW +: IW]),
      .wdata (own_wdata[i*DATA_W +: DATA_W]),
      .q_flat(all_banks[i*BANK_BITS +: BANK_BITS])
    );

    mbx_read_port #(.N_CORES(N_CORES), .REGS(REGS_PER_CORE), .DATA_W(DATA_W)) u_rd (
      .clk      (clk),
      .rst      (rst),
      .en       (rd_en[i]),
      .core_sel (rd_core[i*CW +: CW]),
      .idx_sel  (rd_idx[i*IW +: IW]),
      .bank_flat(all_banks),
      .rdata    (rd_data[i*DATA_W +: DATA_W]),
      .rvalid   (rd_valid[i])
    );

    mbx_ring_tap #(.DATA_W(DATA_W)) u_tap (
      .clk       (clk),
      .rst       (rst),
      .from_left (all_banks[PV*BANK_BITS + mbx_pkg::SLOT_EAST*DATA_W +: DATA_W]),
      .from_right(all_banks[NX*BANK_BITS + mbx_pkg::SLOT_WEST*DATA_W +: DATA_W]),
      .lt_q      (lt_data[i*DATA_W +: DATA_W]),
      .rt_q      (rt_data[i*DATA_W +: DATA_W]),
      .lt_z      (lt_zero[i]),
      .rt_z      (rt_zero[i])
    );
  end
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
  parameter int N_CORES       = 16,
  parameter int REGS_PER_CORE = 16,
  parameter int DATA_W        = 32,
  localparam int IW           = $clog2(REGS_PER_CORE)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_CORES-1:0]        own_we,
  input logic [N_CORES*IW-1:0]     own_idx,
  input logic [N_CORES*DATA_W-1:0] own_wdata,
  input logic [N_CORES-1:0]        rd_en,
  input logic [N_CORES*DATA_W-1:0] rd_data,
  input logic [N_CORES-1:0]        rd_valid,
  input logic [N_CORES*DATA_W-1:0] lt_data,
  input logic [N_CORES*DATA_W-1:0] rt_data,
  input logic [N_CORES-1:0]        lt_zero,
  input logic [N_CORES-1:0]        rt_zero
);
  // Counts clean cycles since reset so that no $past reaches back into reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_valid == '0) && (&lt_zero) && (&rt_zero));

  for (genvar i = 0; i < N_CORES; i++) begin : g_chk
    localparam int PV = mbx_pkg::ring_prev(i, N_CORES);
    localparam int NX = mbx_pkg::ring_next(i, N_CORES);

    p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
      (warm != 2'd0) |-> (rd_valid[i] == $past(rd_en[i])));

    p_data_holds_r3: assert property (@(posedge clk) disable iff (rst)
      (warm != 2'd0) && !$past(rd_en[i]) |-> $stable(rd_data[i*DATA_W +: DATA_W]));

    // R6 and R7: the left view shows word 0 of the previous core, with wrap-around.
    p_left_mail_r6: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) && $past(own_we[PV], 2) &&
      ($past(own_idx[PV*IW +: IW], 2) == IW'(mbx_pkg::SLOT_EAST))
      |-> lt_data[i*DATA_W +: DATA_W] == $past(own_wdata[PV*DATA_W +: DATA_W], 2));

    p_right_mail_r7: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) && $past(own_we[NX], 2) &&
      ($past(own_idx[NX*IW +: IW], 2) == IW'(mbx_pkg::SLOT_WEST))
      |-> rt_data[i*DATA_W +: DATA_W] == $past(own_wdata[NX*DATA_W +: DATA_W], 2));

    p_left_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) && $past(own_we[PV], 2) &&
      ($past(own_idx[PV*IW +: IW], 2) == IW'(mbx_pkg::SLOT_EAST))
      |-> lt_zero[i] == ($past(own_wdata[PV*DATA_W +: DATA_W], 2) == '0));
  end
endmodule

bind nbr_mailbox_bank mbx_checker #(
  .N_CORES(N_CORES), .REGS_PER_CORE(REGS_PER_CORE), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .own_we(own_we), .own_idx(own_idx), .own_wdata(own_wdata),
  .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .lt_data(lt_data),
  .rt_data(rt_data), .lt_zero(lt_zero), .rt_zero(rt_zero)
);

// File: tb/sim_nbr_mailbox_bank.sv
`timescale 1ns/1ps
module sim_nbr_mailbox_bank;
  localparam int NC = 16;
  localparam int NR = 16;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]    own_we = '0;
  logic [NC*IW-1:0] own_idx = '0;
  logic [NC*DW-1:0] own_wdata = '0;
  logic [NC-1:0]    rd_en = '0;
  logic [NC*CW-1:0] rd_core = '0;
  logic [NC*IW-1:0] rd_idx = '0;
  logic [NC*DW-1:0] rd_data, lt_data, rt_data;
  logic [NC-1:0]    rd_valid, lt_zero, rt_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [NC][NR];
  logic [DW-1:0] last_rd [NC];

  always #2.5 clk = ~clk;

  nbr_mailbox_bank #(.N_CORES(NC), .REGS_PER_CORE(NR), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .own_we(own_we), .own_idx(own_idx), .own_wdata(own_wdata),
    .rd_en(rd_en), .rd_core(rd_core), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_valid(rd_valid), .lt_data(lt_data), .rt_data(rt_data),
    .lt_zero(lt_zero), .rt_zero(rt_zero)
  );

  function automatic int prv(input int i); return (i == 0) ? NC - 1 : i - 1; endfunction
  function automatic int nxt(input int i); return (i == NC - 1) ? 0 : i + 1; endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    own_we = '0; rd_en = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle_inputs();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int c = 0; c < NC; c++) begin
      last_rd[c] = '0;
      for (int r = 0; r < NR; r++) mdl[c][r] = '0;
    end
  endtask

  // Applies the present inputs for one edge and checks every output against the model.
  task automatic step(input string rtag);
    logic [DW-1:0] pre [NC][NR];
    bit ok_rd, ok_lt, ok_rt, ok_z;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) pre[c][r] = mdl[c][r];
    @(posedge clk);
    for (int c = 0; c < NC; c++)
      if (own_we[c]) mdl[c][own_idx[c*IW +: IW]] = own_wdata[c*DW +: DW];
    #1;
    for (int j = 0; j < NC; j++) begin
      logic [DW-1:0] e_rd, e_lt, e_rt;
      string mtag;
      e_rd = rd_en[j] ? pre[rd_core[j*CW +: CW]][rd_idx[j*IW +: IW]] : last_rd[j];
      last_rd[j] = e_rd;
      e_lt = pre[prv(j)][0];
      e_rt = pre[nxt(j)][1];
      mtag = (j == 0 || j == NC - 1) ? "R7" : "R6";
      ok_rd = (rd_data[j*DW +: DW] === e_rd);
      chk(ok_rd, rtag, $sformatf("rd_data[%0d]", j), rd_data[j*DW +: DW], e_rd);
      chk(rd_valid[j] === rd_en[j], "R3", $sformatf("rd_valid[%0d]", j),
          DW'(rd_valid[j]), DW'(rd_en[j]));
      ok_lt = (lt_data[j*DW +: DW] === e_lt);
      ok_rt = (rt_data[j*DW +: DW] === e_rt);
      chk(ok_lt, mtag, $sformatf("lt_data[%0d]", j), lt_data[j*DW +: DW], e_lt);
      chk(ok_rt, mtag, $sformatf("rt_data[%0d]", j), rt_data[j*DW +: DW], e_rt);
      ok_z = (lt_zero[j] === (e_lt == '0)) && (rt_zero[j] === (e_rt == '0));
      chk(ok_z, "R8", $sformatf("zero flags[%0d]", j),
          DW'({lt_zero[j], rt_zero[j]}), DW'({e_lt == '0, e_rt == '0}));
    end
  endtask

  task automatic check_reset_state();
    chk(rd_valid === '0, "R1", "rd_valid after reset", DW'(rd_valid), '0);
    chk(rd_data === '0, "R1", "rd_data after reset", rd_data[DW-1:0], '0);
    chk((lt_data === '0) && (rt_data === '0), "R1", "mailbox views after reset",
        lt_data[DW-1:0] | rt_data[DW-1:0], '0);
    chk((&lt_zero) && (&rt_zero), "R1", "zero flags after reset",
        DW'({lt_zero, rt_zero}), {DW{1'b1}});
  endtask

  task automatic read_all_banks(input string tag);
    for (int r = 0; r < NR; r++) begin
      idle_inputs();
      for (int j = 0; j < NC; j++) begin
        rd_en[j] = 1'b1;
        rd_core[j*CW +: CW] = CW'(j);
        rd_idx[j*IW +: IW] = IW'(r);
      end
      step(tag);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    do_reset();
    check_reset_state();
    read_all_banks("R1");

    // R9: every core writes word 3 in the same cycle.
    idle_inputs();
    for (int c = 0; c < NC; c++) begin
      own_we[c] = 1'b1;
      own_idx[c*IW +: IW] = 4'd3;
      own_wdata[c*DW +: DW] = 32'hA500_0000 + DW'(c);
    end
    step("R9");
    read_all_banks("R9");

    // R2: enables low while index and data toggle, then the contents are read back.
    idle_inputs();
    for (int c = 0; c < NC; c++) begin
      own_idx[c*IW +: IW] = 4'd3;
      own_wdata[c*DW +: DW] = 32'hDEAD_BEEF;
    end
    step("R2");
    read_all_banks("R2");

    // R5: a read and a write of the same word at the same edge.
    idle_inputs();
    own_we[5] = 1'b1; own_idx[5*IW +: IW] = 4'd7; own_wdata[5*DW +: DW] = 32'h1234_5678;
    rd_en[2] = 1'b1; rd_core[2*CW +: CW] = 4'd5; rd_idx[2*IW +: IW] = 4'd7;
    step("R5");
    chk(rd_data[2*DW +: DW] === 32'h0, "R5", "old value on collision", rd_data[2*DW +: DW], 0);
    idle_inputs();
    rd_en[2] = 1'b1;
    step("R5");
    chk(rd_data[2*DW +: DW] === 32'h1234_5678, "R5", "new value next read",
        rd_data[2*DW +: DW], 32'h1234_5678);

    // R4: all ports read one word together.
    idle_inputs();
    for (int j = 0; j < NC; j++) begin
      rd_en[j] = 1'b1; rd_core[j*CW +: CW] = 4'd5; rd_idx[j*IW +: IW] = 4'd7;
    end
    step("R4");

    // R7: traffic across the wrap point, followed by two idle edges.
    idle_inputs();
    own_we[NC-1] = 1'b1; own_idx[(NC-1)*IW +: IW] = 4'd0; own_wdata[(NC-1)*DW +: DW] = 32'hC0DE_0F0F;
    own_we[0] = 1'b1; own_idx[0 +: IW] = 4'd1; own_wdata[0 +: DW] = 32'h0BAD_F00D;
    step("R7");
    idle_inputs();
    step("R7");
    step("R7");
    chk(lt_data[0 +: DW] === 32'hC0DE_0F0F, "R7", "core 0 left view",
        lt_data[0 +: DW], 32'hC0DE_0F0F);
    chk(rt_data[(NC-1)*DW +: DW] === 32'h0BAD_F00D, "R7", "last core right view",
        rt_data[(NC-1)*DW +: DW], 32'h0BAD_F00D);

    // R8: clearing a mailbox word raises the zero flag.
    own_we[NC-1] = 1'b1; own_idx[(NC-1)*IW +: IW] = 4'd0; own_wdata[(NC-1)*DW +: DW] = '0;
    step("R8");
    idle_inputs();
    step("R8");

    // R6: random traffic with the write indices biased toward the mailbox words.
    for (int n = 0; n < 600; n++) begin
      for (int c = 0; c < NC; c++) begin
        own_we[c] = ($urandom % 3) == 0;
        own_idx[c*IW +: IW] = ($urandom % 2) ? IW'($urandom % 2) : IW'($urandom);
        own_wdata[c*DW +: DW] = (($urandom % 5) == 0) ? '0 : DW'($urandom);
        rd_en[c] = $urandom % 2;
        rd_core[c*CW +: CW] = CW'($urandom);
        rd_idx[c*IW +: IW] = ($urandom % 2) ? IW'($urandom % 2) : IW'($urandom);
      end
      step("R3");
    end

    // R1: a second reset mid-run clears everything again.
    do_reset();
    check_reset_state();
    read_all_banks("R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule